// File: doc/BRIEF.md
# Snooping Invalidation Cache Controller

This block is the coherence controller of one cache in a small multiprocessor whose caches share a broadcast bus. It holds a tag and a three-state coherence tag for every line of a direct-mapped cache. The three states are invalid, shared (a clean copy that memory also holds) and exclusive (a dirty copy that only this cache owns). The data array is not part of the block.

The processor side uses a valid/ready handshake. `cpuReady` means the request has been taken. A hit is finished at once. A miss or an ownership upgrade is finished later on the bus. The bus is split-transaction: the block sends a request (read, read-for-ownership or writeback) and the response arrives in a separate phase. The block keeps at most one request outstanding, and it marks the target line as in progress until the response comes back. Any new operation on a line in progress is held off. The snooper watches the transactions that other caches broadcast. It invalidates or downgrades its own copies and raises a writeback response when it owns the dirty line.

Top module: `snoopCacheCtl`

## Requirements
- R1: After reset every line is invalid and no line is in progress. `busReqValid`, `cpuReady` (with no request present) and `snpWriteback` are all low.
- R2: A load to a line whose tag matches and whose state is shared or exclusive raises `cpuReady` in the same cycle and issues no bus request.
- R3: A store to an exclusive line whose tag matches raises `cpuReady` in the same cycle and issues no bus request.
- R4: A store to a shared line whose tag matches issues a read-for-ownership (`busReqCmd` = 2) for the request address. The line becomes exclusive only when the response arrives.
- R5: A load miss issues a read (`busReqCmd` = 1) for the request address. The request stays on the bus unchanged until `busReqReady`. When the response arrives the line becomes shared.
- R6: A store miss issues a read-for-ownership. When the response arrives the line becomes exclusive.
- R7: A miss whose victim line is exclusive first issues a writeback (`busReqCmd` = 3) carrying the victim's address, then the fill request. After that the victim's address no longer hits.
- R8: A snooped read (`snpCmd` = 1) that hits an exclusive line raises `snpWriteback` in the same cycle. The line then becomes shared.
- R9: A snooped read-for-ownership (`snpCmd` = 2) that hits a line invalidates it. `snpWriteback` is raised only if the line was exclusive.
- R10: While a line is in progress, a request to that line is stalled. Snoops on that line neither change its state nor raise a writeback. A hit on another line is still served. A request that needs the bus waits until the outstanding response has arrived.
- R11: A processor request is stalled in any cycle where a valid snoop addresses the same cache index.
- R12: A snoop whose tag differs from the stored tag has no effect. A snooped writeback (`snpCmd` = 3) also has no effect.
- R13: If a snoop takes the exclusive victim away while the eviction writeback is still waiting for `busReqReady`, the writeback is dropped and the fill request follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Line address; low IDX_W bits are the index |
| cpuReady | output | 1 | Request taken this cycle |
| busReqValid | output | 1 | Bus request presented |
| busReqCmd | output | 2 | 1 read, 2 read-for-ownership, 3 writeback |
| busReqAddr | output | ADDR_W | Bus request address |
| busReqReady | input | 1 | Bus takes the request this cycle |
| busRespValid | input | 1 | Response for the outstanding request |
| snpValid | input | 1 | Another cache's transaction on the bus |
| snpCmd | input | 2 | Snooped command, same encoding as busReqCmd |
| snpAddr | input | ADDR_W | Snooped address |
| snpWriteback | output | 1 | This cache owns the dirty line and supplies it |

## Verification
The bench drives the line through upgrade and eviction paths and snoops it while a transaction is still open. A design that set exclusive when the request was issued instead of when the response arrived would answer a snoop with a false writeback. One that ignored the in-progress marker would accept a second request to the pending line. It also lines a snoop up with a store in the same cycle: a missing conflict stall would let the store hit a line that the snoop has just invalidated. Finally, it steals the victim during a stalled eviction. A controller that went on with the writeback would put a stale writeback on the bus, and the scoreboard of expected requests reports that.

// File: rtl/snoopPkg.sv
package snoopPkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RFO  = 2'd2,
    BUS_WB   = 2'd3
  } busCmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fillIssue;  // fill request taken by the bus
    logic evictClr;   // victim writeback taken by the bus
    logic respDone;   // response for the outstanding request
    logic respExcl;   // outstanding request was a read-for-ownership
  } ctlStrobes_t;
endpackage

// File: rtl/snoopDatapath.sv
module snoopDatapath
  import snoopPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  ctlStrobes_t       strobes,
  input  logic              snpValid,
  input  busCmd_e           snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              cpuTagHit,
  output lineState_e        cpuLineState,
  output logic              cpuLinePend,
  output logic              cpuSnpClash,
  output logic [ADDR_W-IDX_W-1:0] victimTag,
  output logic              victimExcl,
  output logic              snpWriteback
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  lineState_e             stateArr [LINES];
  logic [TAG_W-1:0]       tagArr   [LINES];
  logic [LINES-1:0]       pendArr;
  logic [IDX_W-1:0]       pendIdxQ;

  logic [IDX_W-1:0] cpuIdx, snpIdx, reqIdx;
  logic [TAG_W-1:0] cpuTag, snpTag, reqTag;
  logic             snpMatch;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];
  assign reqIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];

  // processor lookup
  assign cpuLineState = stateArr[cpuIdx];
  assign cpuTagHit    = (tagArr[cpuIdx] == cpuTag) && (stateArr[cpuIdx] != LN_INV);
  assign cpuLinePend  = pendArr[cpuIdx];
  assign cpuSnpClash  = snpValid && (snpIdx == cpuIdx);

  // victim of the latched request
  assign victimTag  = tagArr[reqIdx];
  assign victimExcl = (stateArr[reqIdx] == LN_EXC);

  // snoop lookup; lines in progress are left alone
  assign snpMatch = snpValid && !pendArr[snpIdx] && (tagArr[snpIdx] == snpTag) &&
                    (stateArr[snpIdx] != LN_INV);
  assign snpWriteback = snpMatch && (stateArr[snpIdx] == LN_EXC) &&
                        ((snpCmd == BUS_RD) || (snpCmd == BUS_RFO));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateArr[i] <= LN_INV;
        tagArr[i]   <= '0;
      end
      pendArr  <= '0;
      pendIdxQ <= '0;
    end else begin
      // snoop effect first, control strobes override on the same line
      if (snpMatch) begin
        if (snpCmd == BUS_RFO) stateArr[snpIdx] <= LN_INV;
        else if (snpCmd == BUS_RD && stateArr[snpIdx] == LN_EXC) stateArr[snpIdx] <= LN_SHR;
      end
      if (strobes.evictClr) stateArr[reqIdx] <= LN_INV;
      if (strobes.fillIssue) begin
        if (tagArr[reqIdx] != reqTag) stateArr[reqIdx] <= LN_INV;
        tagArr[reqIdx]  <= reqTag;
        pendArr[reqIdx] <= 1'b1;
        pendIdxQ        <= reqIdx;
      end
      if (strobes.respDone) begin
        stateArr[pendIdxQ] <= strobes.respExcl ? LN_EXC : LN_SHR;
        pendArr[pendIdxQ]  <= 1'b0;
      end
    end
  end

  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pendArr) <= 1); // R10

  AST_RESP_STATE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.respDone |=> (stateArr[$past(pendIdxQ)] ==
                          ($past(strobes.respExcl) ? LN_EXC : LN_SHR))); // R4

  AST_SNOOP_DOWNGRADE: assert property (@(posedge clk) disable iff (!rstN)
    (snpWriteback && snpCmd == BUS_RD && !(snpIdx == reqIdx &&
      (strobes.evictClr || strobes.fillIssue)))
      |=> stateArr[$past(snpIdx)] == LN_SHR); // R8

  AST_PEND_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && pendArr[snpIdx]) |-> !snpWriteback); // R10
endmodule

// File: rtl/snoopControl.sv
module snoopControl
  import snoopPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuTagHit,
  input  lineState_e        cpuLineState,
  input  logic              cpuLinePend,
  input  logic              cpuSnpClash,
  input  logic [ADDR_W-IDX_W-1:0] victimTag,
  input  logic              victimExcl,
  input  logic              busReqReady,
  input  logic              busRespValid,
  output logic              cpuReady,
  output logic              busReqValid,
  output busCmd_e           busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [ADDR_W-1:0] reqAddr,
  output ctlStrobes_t       strobes
);
  ctlState_e         stQ;
  logic [ADDR_W-1:0] reqAddrQ;
  busCmd_e           reqCmdQ;
  logic              outQ, outExclQ;

  logic hitDone, startMiss, evictNeed, lineFree;

  assign hitDone   = cpuTagHit && (!cpuWrite || cpuLineState == LN_EXC);
  assign lineFree  = !cpuLinePend && !cpuSnpClash;
  assign cpuReady  = (stQ == ST_IDLE) && cpuValid && lineFree && (hitDone || !outQ);
  assign startMiss = cpuReady && !hitDone;
  assign evictNeed = !cpuTagHit && (cpuLineState == LN_EXC);
  assign reqAddr   = reqAddrQ;

  always_comb begin
    busReqValid = 1'b0;
    busReqCmd   = BUS_NONE;
    busReqAddr  = reqAddrQ;
    case (stQ)
      ST_EVICT: begin
        busReqValid = victimExcl;
        busReqCmd   = BUS_WB;
        busReqAddr  = {victimTag, reqAddrQ[IDX_W-1:0]};
      end
      ST_FILL: begin
        busReqValid = 1'b1;
        busReqCmd   = reqCmdQ;
      end
      default: ;
    endcase
  end

  always_comb begin
    strobes.evictClr  = (stQ == ST_EVICT) && victimExcl && busReqReady;
    strobes.fillIssue = (stQ == ST_FILL) && busReqReady;
    strobes.respDone  = busRespValid && outQ;
    strobes.respExcl  = outExclQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ      <= ST_IDLE;
      reqAddrQ <= '0;
      reqCmdQ  <= BUS_NONE;
      outQ     <= 1'b0;
      outExclQ <= 1'b0;
    end else begin
      case (stQ)
        ST_IDLE: if (startMiss) begin
          reqAddrQ <= cpuAddr;
          reqCmdQ  <= cpuWrite ? BUS_RFO : BUS_RD;
          stQ      <= evictNeed ? ST_EVICT : ST_FILL;
        end
        ST_EVICT: if (!victimExcl || busReqReady) stQ <= ST_FILL;
        ST_FILL: if (busReqReady) begin
          stQ      <= ST_IDLE;
          outQ     <= 1'b1;
          outExclQ <= (reqCmdQ == BUS_RFO);
        end
        default: stQ <= ST_IDLE;
      endcase
      if (strobes.respDone) outQ <= 1'b0;
    end
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busReqCmd != BUS_WB) |-> !outQ); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_FILL && !busReqReady) |=> busReqValid && $stable(busReqAddr)); // R5

  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (!cpuLinePend && !cpuSnpClash)); // R11

  AST_WB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evictClr |=> (stQ == ST_FILL)); // R7
endmodule

// File: rtl/snoopCacheCtl.sv
module snoopCacheCtl
  import snoopPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuReady,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  input  logic              busReqReady,
  input  logic              busRespValid,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpWriteback
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctlStrobes_t       strobes;
  logic [ADDR_W-1:0] reqAddr;
  logic              cpuTagHit, cpuLinePend, cpuSnpClash, victimExcl;
  lineState_e        cpuLineState;
  logic [TAG_W-1:0]  victimTag;
  busCmd_e           reqCmd;

  assign busReqCmd = reqCmd;

  snoopDatapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .reqAddr(reqAddr), .strobes(strobes),
    .snpValid(snpValid), .snpCmd(busCmd_e'(snpCmd)), .snpAddr(snpAddr),
    .cpuTagHit(cpuTagHit), .cpuLineState(cpuLineState), .cpuLinePend(cpuLinePend),
    .cpuSnpClash(cpuSnpClash), .victimTag(victimTag), .victimExcl(victimExcl),
    .snpWriteback(snpWriteback)
  );

  snoopControl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) ctl_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuTagHit(cpuTagHit), .cpuLineState(cpuLineState), .cpuLinePend(cpuLinePend),
    .cpuSnpClash(cpuSnpClash), .victimTag(victimTag), .victimExcl(victimExcl),
    .busReqReady(busReqReady), .busRespValid(busRespValid), .cpuReady(cpuReady),
    .busReqValid(busReqValid), .busReqCmd(reqCmd), .busReqAddr(busReqAddr),
    .reqAddr(reqAddr), .strobes(strobes)
  );
endmodule

// File: tb/snoopCacheCtl_tb.sv
module snoopCacheCtl_tb_top;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam logic [1:0] C_RD = 2'd1, C_RFO = 2'd2, C_WB = 2'd3;
  localparam logic [ADDR_W-1:0] A_A = 12'h010, A_B = 12'h020, A_C = 12'h013,
                                A_D = 12'h005, A_X = 12'h023, A_E = 12'h033;

  logic clk = 0, rstN = 0;
  logic cpuValid = 0, cpuWrite = 0, busReqReady = 1, busRespValid = 0, snpValid = 0;
  logic [ADDR_W-1:0] cpuAddr = '0, snpAddr = '0;
  logic [1:0] snpCmd = '0;
  logic cpuReady, busReqValid, snpWriteback;
  logic [1:0] busReqCmd;
  logic [ADDR_W-1:0] busReqAddr;

  int checks = 0, errors = 0;
  logic [ADDR_W+1:0] expQ[$];

  always #(PERIOD/2) clk = ~clk;

  snoopCacheCtl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuReady(cpuReady), .busReqValid(busReqValid), .busReqCmd(busReqCmd),
    .busReqAddr(busReqAddr), .busReqReady(busReqReady), .busRespValid(busRespValid),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr), .snpWriteback(snpWriteback)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every request taken by the bus must match the scoreboard head
  always @(negedge clk) begin
    if (rstN && busReqValid && busReqReady) begin
      if (expQ.size() == 0) check(1'b0, "R2 unexpected bus request", {busReqCmd, busReqAddr}, 0);
      else begin
        logic [ADDR_W+1:0] e;
        e = expQ.pop_front();
        check({busReqCmd, busReqAddr} == e, "R5 bus request", {busReqCmd, busReqAddr}, e);
      end
    end
  end

  task automatic push(input logic [1:0] cmd, input logic [ADDR_W-1:0] a);
    expQ.push_back({cmd, a});
  endtask

  task automatic cpuOp(input bit wr, input logic [ADDR_W-1:0] a, input string req);
    int waited;
    waited = 0;
    @(posedge clk); #1;
    cpuValid = 1; cpuWrite = wr; cpuAddr = a;
    forever begin
      @(negedge clk);
      if (cpuReady || waited > 20) break;
      waited++;
    end
    check(waited == 0, req, waited, 0);
    @(posedge clk); #1 cpuValid = 0;
  endtask

  task automatic stallCheck(input bit wr, input logic [ADDR_W-1:0] a, input string req);
    @(posedge clk); #1;
    cpuValid = 1; cpuWrite = wr; cpuAddr = a;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(cpuReady == 1'b0, req, cpuReady, 0);
    end
    @(posedge clk); #1 cpuValid = 0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a, input bit expWb,
                       input string req);
    @(posedge clk); #1;
    snpValid = 1; snpCmd = cmd; snpAddr = a;
    @(negedge clk);
    check(snpWriteback == expWb, req, snpWriteback, expWb);
    @(posedge clk); #1 snpValid = 0;
  endtask

  task automatic respond();
    repeat (3) @(posedge clk);
    #1 busRespValid = 1;
    @(posedge clk); #1 busRespValid = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(busReqValid == 0, "R1 busReqValid", busReqValid, 0);
    check(cpuReady == 0, "R1 cpuReady", cpuReady, 0);
    check(snpWriteback == 0, "R1 snpWriteback", snpWriteback, 0);
    snoop(C_RD, A_A, 0, "R1 invalid after reset");

    // load miss, line in progress
    push(C_RD, A_A); cpuOp(0, A_A, "R5 load miss taken");
    stallCheck(0, A_A, "R10 stall on pending line");
    snoop(C_RFO, A_A, 0, "R10 snoop on pending line");
    respond();
    cpuOp(0, A_A, "R2 load hit shared");
    snoop(C_RD, A_A, 0, "R5 line shared after fill");

    // upgrade
    push(C_RFO, A_A); cpuOp(1, A_A, "R4 store to shared taken");
    snoop(C_RD, A_A, 0, "R4 not exclusive before response");
    respond();
    cpuOp(1, A_A, "R3 store hit exclusive");
    snoop(C_RD, A_A, 1, "R8 snoop read on exclusive");
    push(C_RFO, A_A); cpuOp(1, A_A, "R8 line now shared needs upgrade");
    respond();

    // outstanding transaction on another line
    push(C_RFO, A_D); cpuOp(1, A_D, "R6 store miss taken");
    cpuOp(0, A_A, "R10 hit on other line while outstanding");
    stallCheck(0, A_C, "R10 miss waits for outstanding");
    respond();
    snoop(C_RFO, A_D, 1, "R9 snoop rfo on exclusive");
    push(C_RD, A_D); cpuOp(0, A_D, "R9 line invalid after snoop");
    respond();
    snoop(C_RFO, A_D, 0, "R9 snoop rfo on shared");
    push(C_RD, A_D); cpuOp(0, A_D, "R9 shared line invalidated");
    respond();

    // eviction of exclusive victim
    push(C_WB, A_A); push(C_RD, A_B); cpuOp(0, A_B, "R7 conflict miss taken");
    respond();
    snoop(C_RD, A_A, 0, "R7 victim gone");
    snoop(C_RD, A_B, 0, "R7 new line shared");

    // store miss becomes exclusive
    push(C_RFO, A_C); cpuOp(1, A_C, "R6 store miss");
    respond();
    snoop(C_RD, A_C, 1, "R6 exclusive after response");
    push(C_RFO, A_C); cpuOp(1, A_C, "R4 upgrade again");
    respond();

    // snoop and store on the same index in one cycle
    push(C_RFO, A_C);
    @(posedge clk); #1;
    cpuValid = 1; cpuWrite = 1; cpuAddr = A_C;
    snpValid = 1; snpCmd = C_RFO; snpAddr = A_C;
    @(negedge clk);
    check(cpuReady == 0, "R11 stall on snoop clash", cpuReady, 0);
    check(snpWriteback == 1, "R9 clash snoop writeback", snpWriteback, 1);
    @(posedge clk); #1 snpValid = 0;
    @(negedge clk);
    check(cpuReady == 1, "R11 taken as miss after clash", cpuReady, 1);
    @(posedge clk); #1 cpuValid = 0;
    respond();

    // unrelated snoops
    snoop(C_RD, A_X, 0, "R12 tag mismatch");
    snoop(C_WB, A_C, 0, "R12 snooped writeback");
    cpuOp(1, A_C, "R12 line still exclusive");

    // victim stolen during stalled eviction
    busReqReady = 0;
    cpuOp(0, A_E, "R13 conflict miss taken");
    @(negedge clk);
    check(busReqValid && busReqCmd == C_WB && busReqAddr == A_C, "R7 writeback presented",
          {busReqValid, busReqCmd, busReqAddr}, {1'b1, C_WB, A_C});
    snoop(C_RFO, A_C, 1, "R13 snoop takes victim");
    @(negedge clk);
    check(busReqValid == 0, "R13 writeback dropped", busReqValid, 0);
    @(negedge clk);
    check(busReqValid && busReqCmd == C_RD && busReqAddr == A_E, "R13 fill follows",
          {busReqValid, busReqCmd, busReqAddr}, {1'b1, C_RD, A_E});
    push(C_RD, A_E);
    @(posedge clk); #1 busReqReady = 1;
    respond();
    cpuOp(0, A_E, "R2 hit after fill");

    repeat (4) @(posedge clk);
    check(expQ.size() == 0, "R7 all expected requests seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule